// File: doc/BRIEF.md
# High-Rate Refresh Interrupt Logic

This block lets a character display controller take in characters faster than one per frame. In normal refresh the controller accepts one character for each vertical retrace, which is 60 characters per second at a 60 Hz frame rate, or 600 baud. When the line rate is set above that and a character is waiting, the block raises an artificial-retrace flag. The flag blanks the screen, stops the row and line counters from advancing, and gives the sequencer a long service window. The incoming character must be handled within about half a millisecond of the flag rising.

The flag can rise only at one decode point of the sequencer: the edge where all three phase bits are zero. It stays up until the real vertical retrace arrives while the sequencer is in a chosen clear phase. After that, normal refresh resumes. The baud-select level and the active-low pending signal come from another board. Each passes through its own flip-flop synchroniser before it is used. The phase bits and the real retrace are already in this clock domain.

Top module: `hirate_retrace_inject`

## Requirements
- R1: A synchronous active-high reset clears the flag. After reset, blank_n_o is 1, adv_inhibit_o is 0 and art_vret_o is 0.
- R2: The flag sets at a clock edge when all four of these hold: the synchronised fast_baud_i is 1 (1 means above 600 baud), the synchronised pend_n_i is 0, seq_phase_i equals 3'b000, and no clear condition is present.
- R3: At any seq_phase_i value other than 3'b000, a pending character does not set the flag.
- R4: While fast_baud_i is 0 (600 baud or below), the flag never sets, even with pend_n_i at 0.
- R5: While pend_n_i is 1 (nothing pending), the flag never sets.
- R6: While the flag is set, art_vret_o is 1, blank_n_o is 0 (active-low blank) and adv_inhibit_o is 1. While it is clear, the outputs are 1, 0 and 0 for blank_n_o, adv_inhibit_o and art_vret_o.
- R7: Once set, the flag holds through any change of fast_baud_i or pend_n_i, and through real_vret_i at any phase other than CLEAR_PHASE (default 3'b111). It clears at the edge where real_vret_i is 1 and seq_phase_i equals CLEAR_PHASE.
- R8: fast_baud_i and pend_n_i each pass through SYNC_STAGES flip-flops (default 2). A value driven before clock edge j is first used by the flag logic at edge j+SYNC_STAGES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous active-high reset |
| fast_baud_i | input | 1 | 1 when the selected line rate is above 600 baud |
| pend_n_i | input | 1 | Active-low: a character waits at the serial or parallel port |
| seq_phase_i | input | 3 | Sequencer phase bits |
| real_vret_i | input | 1 | Real vertical retrace from the video timing |
| blank_n_o | output | 1 | Active-low screen blank |
| adv_inhibit_o | output | 1 | Stops row/line advance while high |
| art_vret_o | output | 1 | Artificial retrace in progress |

## Verification
The bench builds the block with SYNC_STAGES=2 and CLEAR_PHASE=3'b111. With these values the two-edge synchroniser delay can be observed: a pending edge that coincides with phase zero sets nothing until two edges later. Because the clear phase differs from the set phase, the hold behaviour can be tested apart from the clear. This covers a retrace at the wrong phase and a clear at the right one. Phase sweeps with each qualifying input held inactive in turn cover every path that must not set the flag.

// File: rtl/hrri_pkg.sv
package hrri_pkg;
    localparam int PHASE_W = 3;
    typedef logic [PHASE_W-1:0] phase_t;

    // Phase at which a pending character may open the artificial retrace.
    localparam phase_t SET_PHASE = '0;

    typedef struct packed {
        logic set_req;
        logic clr_req;
    } flag_ctl_t;

    typedef struct packed {
        logic blank_n;
        logic adv_inhibit;
        logic art_vret;
    } disp_ctl_t;

    function automatic logic phase_is(input phase_t ph, input phase_t target);
        return ph == target;
    endfunction

    function automatic disp_ctl_t disp_from_flag(input logic flag);
        disp_ctl_t d;
        d.blank_n     = ~flag;
        d.adv_inhibit = flag;
        d.art_vret    = flag;
        return d;
    endfunction
endpackage

// File: rtl/hrri_sync.sv
module hrri_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= RST_VAL;
                    else     chain[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= RST_VAL;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/hrri_decode.sv
module hrri_decode
    import hrri_pkg::*;
#(
    parameter phase_t CLEAR_PHASE = '1
) (
    input  logic      fast_s_i,
    input  logic      pend_n_s_i,
    input  phase_t    phase_i,
    input  logic      vret_i,
    output flag_ctl_t ctl_o
);
    always_comb begin
        ctl_o.set_req = fast_s_i && !pend_n_s_i && phase_is(phase_i, SET_PHASE);
        ctl_o.clr_req = vret_i && phase_is(phase_i, CLEAR_PHASE);
    end
endmodule

// File: rtl/hrri_flag.sv
module hrri_flag
    import hrri_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  flag_ctl_t ctl_i,
    output logic      flag_o
);
    always_ff @(posedge clk) begin
        if (rst)                flag_o <= 1'b0;
        else if (ctl_i.clr_req) flag_o <= 1'b0;
        else if (ctl_i.set_req) flag_o <= 1'b1;
    end

    a_r2_set: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.set_req && !ctl_i.clr_req) |=> flag_o);
    a_r3_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
        (!flag_o && !ctl_i.set_req) |=> !flag_o);
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (flag_o && !ctl_i.clr_req) |=> flag_o);
    a_r7_clear: assert property (@(posedge clk) disable iff (rst)
        ctl_i.clr_req |=> !flag_o);
endmodule

// File: rtl/hirate_retrace_inject.sv
module hirate_retrace_inject
    import hrri_pkg::*;
#(
    parameter int     SYNC_STAGES = 2,
    parameter phase_t CLEAR_PHASE = '1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fast_baud_i,
    input  logic                pend_n_i,
    input  logic [PHASE_W-1:0]  seq_phase_i,
    input  logic                real_vret_i,
    output logic                blank_n_o,
    output logic                adv_inhibit_o,
    output logic                art_vret_o
);
    logic      fast_s;
    logic      pend_n_s;
    flag_ctl_t ctl;
    logic      flag;
    disp_ctl_t disp;

    hrri_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_baud (
        .clk(clk), .rst(rst), .d_i(fast_baud_i), .q_o(fast_s));

    hrri_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_pend (
        .clk(clk), .rst(rst), .d_i(pend_n_i), .q_o(pend_n_s));

    hrri_decode #(.CLEAR_PHASE(CLEAR_PHASE)) u_decode (
        .fast_s_i(fast_s), .pend_n_s_i(pend_n_s), .phase_i(seq_phase_i),
        .vret_i(real_vret_i), .ctl_o(ctl));

    hrri_flag u_flag (.clk(clk), .rst(rst), .ctl_i(ctl), .flag_o(flag));

    assign disp          = disp_from_flag(flag);
    assign blank_n_o     = disp.blank_n;
    assign adv_inhibit_o = disp.adv_inhibit;
    assign art_vret_o    = disp.art_vret;

    // R4: with the synchronised rate select low, an idle flag stays idle
    a_r4_slow_idle: assert property (@(posedge clk) disable iff (rst)
        (!fast_s && !art_vret_o) |=> !art_vret_o);
    // R5: nothing pending keeps an idle flag idle
    a_r5_no_pend_idle: assert property (@(posedge clk) disable iff (rst)
        (pend_n_s && !art_vret_o) |=> !art_vret_o);
    // R6: the blanking and inhibit outputs never disagree
    a_r6_outputs_agree: assert property (@(posedge clk) disable iff (rst)
        adv_inhibit_o == !blank_n_o);
endmodule

// File: tb/hirate_retrace_inject_tb.sv
module hirate_retrace_inject_tb;
    localparam int       S  = 2;
    localparam bit [2:0] CP = 3'b111;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fast_baud = 1'b0, pend_n = 1'b1, vret = 1'b0;
    logic [2:0] phase = 3'd0;
    logic blank_n, adv_inh, art;

    always #10 clk = ~clk;  // 50 MHz

    hirate_retrace_inject #(.SYNC_STAGES(S), .CLEAR_PHASE(CP)) u_dut (
        .clk(clk), .rst(rst), .fast_baud_i(fast_baud), .pend_n_i(pend_n),
        .seq_phase_i(phase), .real_vret_i(vret), .blank_n_o(blank_n),
        .adv_inhibit_o(adv_inh), .art_vret_o(art));

    typedef struct {
        logic  flag;
        string req;
    } exp_t;

    exp_t q[$];
    int checks = 0, failures = 0;
    bit done = 0;
    logic m_flag = 1'b0;
    logic p_baud[S];
    logic p_pend[S];

    task automatic check_outs(input logic f, input string req);
        checks++;
        if (blank_n !== ~f || adv_inh !== f || art !== f) begin
            failures++;
            $display("FAIL %s: got blank_n=%b adv=%b art=%b expected %b %b %b",
                     req, blank_n, adv_inh, art, ~f, f, f);
        end
    endtask

    // Driver: sets inputs for the next edge and queues the expected result
    task automatic step(input logic b, input logic pn, input logic [2:0] ph,
                        input logic v, input string req);
        logic sb, sp;
        exp_t e;
        @(negedge clk);
        fast_baud = b; pend_n = pn; phase = ph; vret = v;
        sb = p_baud[S-1];
        sp = p_pend[S-1];
        for (int i = S-1; i > 0; i--) begin
            p_baud[i] = p_baud[i-1];
            p_pend[i] = p_pend[i-1];
        end
        p_baud[0] = b;
        p_pend[0] = pn;
        if (v && ph == CP)                      m_flag = 1'b0;
        else if (sb && !sp && ph == 3'b000)     m_flag = 1'b1;
        e.flag = m_flag;
        e.req  = req;
        q.push_back(e);
    endtask

    // Monitor: compares 5 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check_outs(e.flag, e.req);
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < S; i++) begin p_baud[i] = 1'b0; p_pend[i] = 1'b1; end
        repeat (3) @(negedge clk);
        #5 check_outs(1'b0, "R1 reset");
        @(negedge clk);
        rst = 1'b0;

        // R4: slow rate, data pending, all phases
        for (int k = 0; k < 16; k++) step(1'b0, 1'b0, 3'(k), 1'b0, "R4 slow rate");
        // R5: fast rate, nothing pending
        for (int k = 0; k < 16; k++) step(1'b1, 1'b1, 3'(k), 1'b0, "R5 no pending");
        // R3: pending at non-zero phases only
        for (int k = 1; k < 7; k++) step(1'b1, 1'b0, 3'(k), 1'b0, "R3 wrong phase");
        // R2 / R6: phase zero sets the flag, outputs blank and inhibit
        step(1'b1, 1'b0, 3'd0, 1'b0, "R2 set at phase 0");
        step(1'b1, 1'b0, 3'd1, 1'b0, "R6 outputs active");
        // R7: hold through input changes and mistimed retrace
        step(1'b0, 1'b1, 3'd2, 1'b0, "R7 hold inputs drop");
        step(1'b0, 1'b1, 3'd5, 1'b1, "R7 retrace wrong phase");
        step(1'b0, 1'b1, 3'd7, 1'b0, "R7 clear phase no retrace");
        step(1'b0, 1'b1, 3'd0, 1'b1, "R7 retrace phase 0");
        step(1'b0, 1'b1, 3'd7, 1'b1, "R7 clear");
        step(1'b0, 1'b1, 3'd1, 1'b0, "R6 outputs idle");
        // R8: synchroniser latency
        step(1'b1, 1'b1, 3'd3, 1'b0, "R8 prep");
        step(1'b1, 1'b1, 3'd3, 1'b0, "R8 prep");
        step(1'b1, 1'b0, 3'd0, 1'b0, "R8 same edge no set");
        step(1'b1, 1'b0, 3'd0, 1'b0, "R8 one edge no set");
        step(1'b1, 1'b0, 3'd0, 1'b0, "R8 set after two edges");
        step(1'b1, 1'b0, 3'd7, 1'b1, "R7 clear again");
        // Clear then re-set on a later pass through phase zero
        for (int k = 0; k < 10; k++) step(1'b1, 1'b0, 3'(k), 1'b0, "R2 re-set after clear");
        step(1'b1, 1'b0, 3'd7, 1'b1, "R7 clear final");
        // R8: baud select also delayed
        step(1'b0, 1'b0, 3'd1, 1'b0, "R8 baud prep");
        step(1'b0, 1'b0, 3'd2, 1'b0, "R8 baud prep");
        step(1'b1, 1'b0, 3'd0, 1'b0, "R8 baud same edge");
        step(1'b1, 1'b0, 3'd0, 1'b0, "R8 baud one edge");
        step(1'b1, 1'b0, 3'd0, 1'b0, "R8 baud two edges");
        repeat (3) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule